// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps a multicycle datapath through instruction execution by reading control words from a small embedded microprogram. It keeps a micro-address register and a registered copy of the current microinstruction. Each microinstruction carries a two-bit sequencing field that picks the next micro-address. The choices are the current address plus one, a first opcode-indexed dispatch table, a second dispatch table that splits loads from stores, or the fetch entry at address 0. The datapath control fields of the registered microinstruction drive the output ports directly.

The opcode input is taken to come from an external instruction register. It is consulted only while the sequencer sits at the decode or memory-address micro-op. Every routine ends with an explicit jump back to fetch. There are sixteen named micro-ops (states), with these transitions:
- FETCH(0) increments to DECODE(1).
- DECODE dispatches through table 1 to one of the following targets:
  - MEMADDR(2)
  - ALUR_EXEC(6)
  - ALUI_EXEC(8)
  - JUMP(10)
  - JREG(11)
  - BRANCH(12)
  - LINK(13)
  - SYSCALL(14)
  - TRAP(15)
- MEMADDR dispatches through table 2 to LD_ISSUE(3) or ST_ISSUE(5).
- LD_ISSUE increments to LD_WB(4).
- ALUR_EXEC increments to ALUR_WB(7).
- ALUI_EXEC increments to ALUI_WB(9).
- LD_WB, ST_ISSUE, ALUR_WB, ALUI_WB and JUMP through TRAP all return to FETCH.

Opcode encodings are as follows:

| Opcode | Class |
|--------|-------|
| 0 | register ALU |
| 1 | immediate ALU |
| 2 | load |
| 3 | store |
| 4 | jump |
| 5 | register jump |
| 6 | branch |
| 7 | jump-and-link |
| 8 | system call |

Top module: `micro_sequencer`

## Requirements
- R1: While rst_n is low, and asynchronously on its fall, upc is 0 and the outputs hold the fetch word: mem_rd=1, ir_we=1, pc_we=1, pc_src=3, mem_wr=0, rf_we=0.
- R2: Address 0 is always followed by address 1. At address 1, mem_rd, mem_wr, rf_we and pc_we are 0, and the next address comes from dispatch table 1 using the opcode.
- R3: Opcode 2 gives the trace 0,1,2,3,4. At address 3, mem_rd=1 and addr_data=1. At address 4, rf_we=1, dst_sel=0 (rt) and wb_sel=0 (memory data).
- R4: Opcode 3 gives the trace 0,1,2,5. At address 5, mem_wr=1 and rf_we=0.
- R5: Opcode 0 gives the trace 0,1,6,7. At address 7, rf_we=1, dst_sel=1 (rd) and wb_sel=1 (ALU result).
- R6: Opcode 1 gives the trace 0,1,8,9. At address 9, rf_we=1, dst_sel=0 (rt) and wb_sel=1.
- R7: Each control-transfer opcode runs a single micro-op after decode:
  - Opcode 4 goes to 10 with pc_src=0 and pc_we=1.
  - Opcode 5 goes to 11 with pc_src=1 and pc_we=1.
  - Opcode 6 goes to 12 with pc_src=2, pc_cond=1 and pc_we=0.
  - Opcode 7 goes to 13 with pc_src=0, pc_we=1, rf_we=1, dst_sel=2 and wb_sel=2 (PC).
  - Opcode 8 goes to 14 with pc_src=0, pc_we=1 and tgt_sel=1.
- R8: Any opcode of 9 or above dispatches to address 15, which sets pc_we=1, pc_src=0 and tgt_sel=1.
- R9: The cycle after the last micro-op of every routine (4, 5, 7, 9, 10 to 15) has upc=0.
- R10: mem_rd and mem_wr are never 1 together, and rf_we is 1 only at addresses 4, 7, 9 and 13.
- R11: The opcode value has no effect on the sequence except at addresses 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode from the instruction register |
| upc | output | 5 | Current micro-address |
| pc_src | output | 2 | PC source: 0 target, 1 register, 2 branch, 3 sequential |
| pc_we | output | 1 | Unconditional PC write |
| pc_cond | output | 1 | PC write if branch condition holds |
| tgt_sel | output | 1 | Target select: 0 jump field, 1 trap vector |
| addr_data | output | 1 | Memory address from data address register (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register write |
| x_sel | output | 1 | ALU X operand: 0 PC, 1 register |
| y_sel | output | 2 | ALU Y operand: 0 four, 1 register, 2 immediate, 3 immediate times four |
| alu_fn | output | 2 | ALU operation: 0 add, 1 subtract, 2 from function field |
| dst_sel | output | 2 | Destination register: 0 rt, 1 rd, 2 link |
| wb_sel | output | 2 | Write-back data: 0 memory, 1 ALU, 2 PC |
| rf_we | output | 1 | Register file write |

## Verification
A corrupted micro-address or a wrong dispatch entry shows up on upc one cycle after the faulty decode or memory-address step. It stays visible, because the routine then runs through the wrong micro-ops and emits the wrong write enables. A wrong control word in the microprogram appears on the control ports during the same cycle in which that micro-op is current. A wrong return field shows as a nonzero upc in the cycle after a routine's last step. Checking the full trace and the control outputs at every step of every instruction class therefore exposes each of these faults within one instruction.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OP_W = 6;
    localparam int UA_W = 5;

    localparam logic [OP_W-1:0] OPC_ALU_REG = 6'd0;
    localparam logic [OP_W-1:0] OPC_ALU_IMM = 6'd1;
    localparam logic [OP_W-1:0] OPC_LOAD    = 6'd2;
    localparam logic [OP_W-1:0] OPC_STORE   = 6'd3;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'd4;
    localparam logic [OP_W-1:0] OPC_JREG    = 6'd5;
    localparam logic [OP_W-1:0] OPC_BRANCH  = 6'd6;
    localparam logic [OP_W-1:0] OPC_LINK    = 6'd7;
    localparam logic [OP_W-1:0] OPC_SYS     = 6'd8;

    // order is the next-address multiplexer input number
    typedef enum logic [1:0] {
        SEQ_INCR  = 2'd0,
        SEQ_TBL1  = 2'd1,
        SEQ_TBL2  = 2'd2,
        SEQ_FETCH = 2'd3
    } seq_e;

    typedef enum logic [UA_W-1:0] {
        UA_FETCH     = 5'd0,
        UA_DECODE    = 5'd1,
        UA_MEMADDR   = 5'd2,
        UA_LD_ISSUE  = 5'd3,
        UA_LD_WB     = 5'd4,
        UA_ST_ISSUE  = 5'd5,
        UA_ALUR_EXEC = 5'd6,
        UA_ALUR_WB   = 5'd7,
        UA_ALUI_EXEC = 5'd8,
        UA_ALUI_WB   = 5'd9,
        UA_JUMP      = 5'd10,
        UA_JREG      = 5'd11,
        UA_BRANCH    = 5'd12,
        UA_LINK      = 5'd13,
        UA_SYSCALL   = 5'd14,
        UA_TRAP      = 5'd15
    } uaddr_e;

    typedef enum logic [1:0] {
        PCS_TARGET = 2'd0,
        PCS_REG    = 2'd1,
        PCS_BRANCH = 2'd2,
        PCS_SEQ    = 2'd3
    } pcsrc_e;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_SUB  = 2'd1,
        ALU_FN   = 2'd2,
        ALU_PASS = 2'd3
    } alufn_e;

    typedef struct packed {
        seq_e       seq;
        pcsrc_e     pc_src;
        logic       pc_we;
        logic       pc_cond;
        logic       tgt_sel;
        logic       addr_data;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_we;
        logic       x_sel;
        logic [1:0] y_sel;
        alufn_e     alu_fn;
        logic [1:0] dst_sel;
        logic [1:0] wb_sel;
        logic       rf_we;
    } uword_t;

    // microprogram contents, one control word per micro-address
    function automatic uword_t rom_word(uaddr_e a);
        uword_t w;
        w     = '0;
        w.seq = SEQ_FETCH;
        case (a)
            UA_FETCH: begin
                w.seq    = SEQ_INCR;
                w.mem_rd = 1'b1;
                w.ir_we  = 1'b1;
                w.y_sel  = 2'd0;
                w.alu_fn = ALU_ADD;
                w.pc_src = PCS_SEQ;
                w.pc_we  = 1'b1;
            end
            UA_DECODE: begin
                w.seq    = SEQ_TBL1;
                w.y_sel  = 2'd3;
                w.alu_fn = ALU_ADD;
            end
            UA_MEMADDR: begin
                w.seq    = SEQ_TBL2;
                w.x_sel  = 1'b1;
                w.y_sel  = 2'd2;
                w.alu_fn = ALU_ADD;
            end
            UA_LD_ISSUE: begin
                w.seq       = SEQ_INCR;
                w.addr_data = 1'b1;
                w.mem_rd    = 1'b1;
            end
            UA_LD_WB: begin
                w.dst_sel = 2'd0;
                w.wb_sel  = 2'd0;
                w.rf_we   = 1'b1;
            end
            UA_ST_ISSUE: begin
                w.addr_data = 1'b1;
                w.mem_wr    = 1'b1;
            end
            UA_ALUR_EXEC: begin
                w.seq    = SEQ_INCR;
                w.x_sel  = 1'b1;
                w.y_sel  = 2'd1;
                w.alu_fn = ALU_FN;
            end
            UA_ALUR_WB: begin
                w.dst_sel = 2'd1;
                w.wb_sel  = 2'd1;
                w.rf_we   = 1'b1;
            end
            UA_ALUI_EXEC: begin
                w.seq    = SEQ_INCR;
                w.x_sel  = 1'b1;
                w.y_sel  = 2'd2;
                w.alu_fn = ALU_FN;
            end
            UA_ALUI_WB: begin
                w.dst_sel = 2'd0;
                w.wb_sel  = 2'd1;
                w.rf_we   = 1'b1;
            end
            UA_JUMP: begin
                w.pc_src = PCS_TARGET;
                w.pc_we  = 1'b1;
            end
            UA_JREG: begin
                w.pc_src = PCS_REG;
                w.pc_we  = 1'b1;
            end
            UA_BRANCH: begin
                w.x_sel   = 1'b1;
                w.y_sel   = 2'd1;
                w.alu_fn  = ALU_SUB;
                w.pc_src  = PCS_BRANCH;
                w.pc_cond = 1'b1;
            end
            UA_LINK: begin
                w.pc_src  = PCS_TARGET;
                w.pc_we   = 1'b1;
                w.dst_sel = 2'd2;
                w.wb_sel  = 2'd2;
                w.rf_we   = 1'b1;
            end
            UA_SYSCALL, UA_TRAP: begin
                w.pc_src  = PCS_TARGET;
                w.tgt_sel = 1'b1;
                w.pc_we   = 1'b1;
            end
            default: w.seq = SEQ_FETCH;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int TABLE = 1
) (
    input  logic [OP_W-1:0] opcode,
    output uaddr_e          target
);

    generate
        if (TABLE == 1) begin : g_tbl1
            always_comb begin
                case (opcode)
                    OPC_ALU_REG: target = UA_ALUR_EXEC;
                    OPC_ALU_IMM: target = UA_ALUI_EXEC;
                    OPC_LOAD:    target = UA_MEMADDR;
                    OPC_STORE:   target = UA_MEMADDR;
                    OPC_JUMP:    target = UA_JUMP;
                    OPC_JREG:    target = UA_JREG;
                    OPC_BRANCH:  target = UA_BRANCH;
                    OPC_LINK:    target = UA_LINK;
                    OPC_SYS:     target = UA_SYSCALL;
                    default:     target = UA_TRAP;
                endcase
            end
        end else begin : g_tbl2
            always_comb begin
                case (opcode)
                    OPC_LOAD:  target = UA_LD_ISSUE;
                    OPC_STORE: target = UA_ST_ISSUE;
                    default:   target = UA_TRAP;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/useq_next_mux.sv
module useq_next_mux
    import useq_pkg::*;
(
    input  seq_e   sel,
    input  uaddr_e cur,
    input  uaddr_e tbl1,
    input  uaddr_e tbl2,
    output uaddr_e nxt
);

    localparam logic [UA_W-1:0] ONE = {{(UA_W-1){1'b0}}, 1'b1};

    logic [UA_W-1:0] inc;

    always_comb begin
        inc = cur + ONE;
        unique case (sel)
            SEQ_INCR:  nxt = uaddr_e'(inc);
            SEQ_TBL1:  nxt = tbl1;
            SEQ_TBL2:  nxt = tbl2;
            SEQ_FETCH: nxt = UA_FETCH;
            default:   nxt = UA_FETCH;
        endcase
    end

endmodule

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  uaddr_e addr,
    output uword_t word
);

    always_comb word = rom_word(addr);

endmodule

// File: rtl/micro_sequencer.sv
module micro_sequencer
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic [UA_W-1:0] upc,
    output logic [1:0]      pc_src,
    output logic            pc_we,
    output logic            pc_cond,
    output logic            tgt_sel,
    output logic            addr_data,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            ir_we,
    output logic            x_sel,
    output logic [1:0]      y_sel,
    output logic [1:0]      alu_fn,
    output logic [1:0]      dst_sel,
    output logic [1:0]      wb_sel,
    output logic            rf_we
);

    uaddr_e upc_q;
    uaddr_e nxt_addr;
    uaddr_e tbl1_addr;
    uaddr_e tbl2_addr;
    uword_t mir_q;
    uword_t rom_w;

    useq_dispatch #(.TABLE(1)) u_tbl1 (.opcode(opcode), .target(tbl1_addr));
    useq_dispatch #(.TABLE(2)) u_tbl2 (.opcode(opcode), .target(tbl2_addr));

    useq_next_mux u_mux (
        .sel  (mir_q.seq),
        .cur  (upc_q),
        .tbl1 (tbl1_addr),
        .tbl2 (tbl2_addr),
        .nxt  (nxt_addr)
    );

    useq_store u_store (.addr(nxt_addr), .word(rom_w));

    // state register: micro-address and microinstruction load together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc_q <= UA_FETCH;
            mir_q <= rom_word(UA_FETCH);
        end else begin
            upc_q <= nxt_addr;
            mir_q <= rom_w;
        end
    end

    // outputs straight from the microinstruction register
    always_comb begin
        upc       = upc_q;
        pc_src    = mir_q.pc_src;
        pc_we     = mir_q.pc_we;
        pc_cond   = mir_q.pc_cond;
        tgt_sel   = mir_q.tgt_sel;
        addr_data = mir_q.addr_data;
        mem_rd    = mir_q.mem_rd;
        mem_wr    = mir_q.mem_wr;
        ir_we     = mir_q.ir_we;
        x_sel     = mir_q.x_sel;
        y_sel     = mir_q.y_sel;
        alu_fn    = mir_q.alu_fn;
        dst_sel   = mir_q.dst_sel;
        wb_sel    = mir_q.wb_sel;
        rf_we     = mir_q.rf_we;
    end

    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == UA_FETCH) |=> (upc_q == UA_DECODE));

    p_load_issue_then_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == UA_LD_ISSUE) |=> (upc_q == UA_LD_WB && rf_we));

    p_unknown_op_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upc_q == UA_DECODE && opcode > OPC_SYS) |=> (upc_q == UA_TRAP));

    p_return_to_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mir_q.seq == SEQ_FETCH) |=> (upc_q == UA_FETCH && ir_we));

    p_mem_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/test_micro_sequencer.sv
module test_micro_sequencer;
    import useq_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [OP_W-1:0] opcode = '0;
    logic [UA_W-1:0] upc;
    logic [1:0]      pc_src, y_sel, alu_fn, dst_sel, wb_sel;
    logic            pc_we, pc_cond, tgt_sel, addr_data, mem_rd, mem_wr, ir_we, x_sel, rf_we;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    micro_sequencer i_micro_sequencer (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
        .pc_src(pc_src), .pc_we(pc_we), .pc_cond(pc_cond), .tgt_sel(tgt_sel),
        .addr_data(addr_data), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we),
        .x_sel(x_sel), .y_sel(y_sel), .alu_fn(alu_fn), .dst_sel(dst_sel),
        .wb_sel(wb_sel), .rf_we(rf_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int route_len(logic [OP_W-1:0] op);
        if (op == 6'd2) return 5;
        if (op <= 6'd3) return 4;
        return 3;
    endfunction

    function automatic int route_at(logic [OP_W-1:0] op, int k);
        if (k == 0) return 0;
        if (k == 1) return 1;
        if (k == 2) begin
            case (op)
                6'd0: return 6;
                6'd1: return 8;
                6'd2, 6'd3: return 2;
                6'd4: return 10;
                6'd5: return 11;
                6'd6: return 12;
                6'd7: return 13;
                6'd8: return 14;
                default: return 15;
            endcase
        end
        if (k == 3) begin
            case (op)
                6'd0: return 7;
                6'd1: return 9;
                6'd2: return 3;
                default: return 5;
            endcase
        end
        return 4;
    endfunction

    // {upc, mem_rd, mem_wr, rf_we, pc_we, pc_src, pc_cond, tgt_sel, dst_sel, wb_sel}
    function automatic logic [16:0] exp_word(int a);
        logic mr, mw, rw, pw, pc, tg;
        logic [1:0] ps, ds, wb;
        {mr, mw, rw, pw, pc, tg} = '0;
        ps = 2'd0; ds = 2'd0; wb = 2'd0;
        case (a)
            0:  begin mr = 1; pw = 1; ps = 2'd3; end
            3:  mr = 1;
            4:  begin rw = 1; ds = 2'd0; wb = 2'd0; end
            5:  mw = 1;
            7:  begin rw = 1; ds = 2'd1; wb = 2'd1; end
            9:  begin rw = 1; ds = 2'd0; wb = 2'd1; end
            10: pw = 1;
            11: begin pw = 1; ps = 2'd1; end
            12: begin ps = 2'd2; pc = 1; end
            13: begin pw = 1; rw = 1; ds = 2'd2; wb = 2'd2; end
            14, 15: begin pw = 1; tg = 1; end
            default: ;
        endcase
        return {5'(a), mr, mw, rw, pw, ps, pc, tg, ds, wb};
    endfunction

    function automatic string req_tag(int a);
        case (a)
            0: return "R9";
            1: return "R2";
            2, 3, 4: return "R3";
            5: return "R4";
            6, 7: return "R5";
            8, 9: return "R6";
            15: return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [16:0] act_word();
        return {upc, mem_rd, mem_wr, rf_we, pc_we, pc_src, pc_cond, tgt_sel, dst_sel, wb_sel};
    endfunction

    task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_fetch_word(string tag);
        check(tag, {act_word(), ir_we}, {exp_word(0), 1'b1});
    endtask

    // called just after a falling edge with upc expected at 0
    task automatic run_instr(logic [OP_W-1:0] op, int abort_at);
        for (int k = 0; k < route_len(op); k++) begin
            int a;
            a = route_at(op, k);
            check($sformatf("%s/R10/R11 op=%0d step=%0d", req_tag(a), op, k),
                  act_word(), exp_word(a));
            if (a == 3) check("R3 addr_data", {31'd0, addr_data}, 32'd1);
            if (k == abort_at) begin
                rst_n = 1'b0;
                #1;
                check_fetch_word("R1 async reset mid-routine");
                @(negedge clk);
                check_fetch_word("R1 reset held");
                rst_n = 1'b1;
                return;
            end
            // opcode matters only at addresses 1 and 2 (R11)
            if (a == 1 || a == 2) opcode = op;
            else opcode = OP_W'($urandom_range(0, 63));
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        opcode = 6'd63;
        @(negedge clk);
        @(negedge clk);
        check_fetch_word("R1 reset state");
        rst_n = 1'b1;

        // directed: every class plus trap edge values
        for (int op = 0; op <= 9; op++) run_instr(OP_W'(op), -1);
        run_instr(6'd63, -1);
        run_instr(6'd2, 2);
        run_instr(6'd3, -1);
        run_instr(6'd4, 1);
        run_instr(6'd2, -1);

        // constrained random mix, biased toward valid opcodes
        for (int i = 0; i < 400; i++) begin
            logic [OP_W-1:0] op;
            if ($urandom_range(0, 3) == 0) op = OP_W'($urandom_range(0, 63));
            else op = OP_W'($urandom_range(0, 8));
            run_instr(op, -1);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule